// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Fast Vectors

This block gathers interrupt requests from a set of active-low sources. Each source has a falling-edge detector, a pending latch and its own programmable priority level. From the pending sources it picks one winner every cycle and hands the processor core a registered vector number and vector address.

The address normally comes from a table: a programmable base plus two words per vector number. Two fast-vector register pairs can each name one vector number and an absolute 21-bit service address. When the winner matches an enabled pair and runs at level two, that absolute address replaces the table address.

The active-low reset input overrides everything. While it is low, the core sees a fixed reset vector and a reset request. A wake output tells the clocking logic that an enabled request is waiting, so that clocks can restart from a low-power state. The core clears a request by returning its vector number on the acknowledge input.

Top module: `icu_top`

## Requirements
- R1: A source becomes pending only when its input goes from high to low. A line that stays low or stays high never sets pending, including after the pending bit has been cleared.
- R2: A pending bit stays set until an acknowledge names that vector number. An acknowledge clears only the named source. A new falling edge in the same cycle as the acknowledge leaves the bit set.
- R3: Each source has a 2-bit level in bits [1:0] of register 8+n. Level 0 means disabled: a level-0 source never wins and never raises wake. Level 3 is the highest.
- R4: Among pending enabled sources, the one with the highest level wins. On a tie, the lowest vector number wins.
- R5: The normal vector address is base + 2 × vector number, taken modulo 2^21. The base is bits [20:0] of register 0.
- R6: Fast pair 0 uses registers 1 and 2; fast pair 1 uses registers 3 and 4. The number register holds the vector number in its low bits and an enable flag in bit 20. The address register holds a 21-bit absolute address. When the winner equals an enabled pair's number and the winner's level is 2, the pair's address is output.
- R7: At any level other than 2, a winner that matches a fast pair gets the normal table address.
- R8: When both enabled pairs name the winning vector, pair 0's address is used.
- R9: While rst_n is low, core_rst_req_o is 1, vec_addr_o equals RESET_VEC (default 21'h1F0000) and irq_valid_o is 0. All registers and pending bits clear to zero.
- R10: wake_o is 1 exactly when some pending source has a non-zero level.
- R11: The outputs are registered. A falling edge sampled at clock edge k sets pending at edge k, and the outputs reflect it at edge k+1. With no winner, irq_valid_o, irq_num_o and vec_addr_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, highest-priority event |
| irq_n | input | NUM_SRC | Active-low interrupt lines, one per vector number |
| ack_valid_i | input | 1 | Core acknowledges servicing a vector |
| ack_num_i | input | $clog2(NUM_SRC) | Vector number being acknowledged |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | $clog2(8+NUM_SRC) | Register address |
| wr_data_i | input | ADDR_W | Register write data |
| irq_valid_o | output | 1 | A winning request is presented |
| irq_num_o | output | $clog2(NUM_SRC) | Winning vector number |
| vec_addr_o | output | ADDR_W | Vector address for the core |
| wake_o | output | 1 | Request to restart clocks |
| core_rst_req_o | output | 1 | Reset request to the core |

## Verification
The arbiter is tried with three patterns:
- a single source, which checks the table arithmetic;
- three simultaneous sources at mixed levels, which separates highest-level selection from lowest-number tie breaking as they are acknowledged one by one;
- a higher-level late arrival while a lower one waits, which shows that an acknowledge clears only its own source.

Held-low and held-high lines separate edge detection from level detection. An acknowledge that coincides with a new edge separates set-wins from clear-wins.

The fast-vector path is exercised with the matching source at level 2 and then at level 3. It is also exercised with both pairs naming the same vector and then with pair 0 disabled, which shows level gating, pair precedence and the enable flag separately.

// File: rtl/icu_pkg.sv
package icu_pkg;
    // register map (word addresses)
    localparam int REG_BASE    = 0;
    localparam int REG_FNUM0   = 1;  // fast pair p number at 1 + 2p
    localparam int REG_FADDR0  = 2;  // fast pair p address at 2 + 2p
    localparam int PRIO_OFS    = 8;  // level of source n at PRIO_OFS + n
    localparam int NUM_FAST    = 2;
    localparam int LVL_W       = 2;
    localparam int FAST_LVL    = 2;
endpackage

// File: rtl/icu_pend.sv
module icu_pend #(
    parameter int NUM_SRC = 8,
    localparam int VW = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_n,
    input  logic               ack_valid,
    input  logic [VW-1:0]      ack_num,
    output logic [NUM_SRC-1:0] pend_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
        logic [NUM_SRC-1:0] pend;
    } st_t;

    st_t s_d, s_q;
    logic [NUM_SRC-1:0] fall, clr;

    always_comb begin
        fall   = s_q.prev & ~irq_n;
        clr    = ack_valid ? (NUM_SRC'(1) << ack_num) : '0;
        s_d    = s_q;
        s_d.prev = irq_n;
        s_d.pend = (s_q.pend & ~clr) | fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.prev <= '1;
            s_q.pend <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;

    // R2
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && int'(ack_num) < NUM_SRC && !fall[ack_num]) |=> !pend_o[$past(ack_num)]);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        // R1
        fall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.prev[i] && !irq_n[i]) |=> pend_o[i]);
        // R2
        pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[i] && !(ack_valid && int'(ack_num) == i)) |=> pend_o[i]);
    end
endmodule

// File: rtl/icu_regs.sv
module icu_regs #(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 21,
    localparam int VW   = $clog2(NUM_SRC),
    localparam int RAW  = $clog2(icu_pkg::PRIO_OFS + NUM_SRC),
    localparam int LW   = icu_pkg::LVL_W,
    localparam int NF   = icu_pkg::NUM_FAST,
    localparam int EN_BIT = ADDR_W - 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [RAW-1:0]             wr_addr,
    input  logic [ADDR_W-1:0]          wr_data,
    output logic [ADDR_W-1:0]          base_o,
    output logic [NUM_SRC-1:0][LW-1:0] lvl_o,
    output logic [NF-1:0]              fen_o,
    output logic [NF-1:0][VW-1:0]      fnum_o,
    output logic [NF-1:0][ADDR_W-1:0]  faddr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0]          base;
        logic [NUM_SRC-1:0][LW-1:0] lvl;
        logic [NF-1:0]              fen;
        logic [NF-1:0][VW-1:0]      fnum;
        logic [NF-1:0][ADDR_W-1:0]  faddr;
    } rf_t;

    rf_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (int'(wr_addr) == icu_pkg::REG_BASE) r_d.base = wr_data;
            for (int p = 0; p < NF; p++) begin
                if (int'(wr_addr) == icu_pkg::REG_FNUM0 + 2 * p) begin
                    r_d.fnum[p] = wr_data[VW-1:0];
                    r_d.fen[p]  = wr_data[EN_BIT];
                end
                if (int'(wr_addr) == icu_pkg::REG_FADDR0 + 2 * p)
                    r_d.faddr[p] = wr_data;
            end
            for (int n = 0; n < NUM_SRC; n++)
                if (int'(wr_addr) == icu_pkg::PRIO_OFS + n) r_d.lvl[n] = wr_data[LW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign base_o  = r_q.base;
    assign lvl_o   = r_q.lvl;
    assign fen_o   = r_q.fen;
    assign fnum_o  = r_q.fnum;
    assign faddr_o = r_q.faddr;

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_wchk
        // R3
        lvl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(wr_addr) == icu_pkg::PRIO_OFS + n) |=> lvl_o[n] == $past(wr_data[LW-1:0]));
    end
endmodule

// File: rtl/icu_arb.sv
module icu_arb #(
    parameter int NUM_SRC = 8,
    localparam int VW = $clog2(NUM_SRC),
    localparam int LW = icu_pkg::LVL_W
) (
    input  logic [NUM_SRC-1:0]         pend,
    input  logic [NUM_SRC-1:0][LW-1:0] lvl,
    output logic                       win_valid,
    output logic [VW-1:0]              win_num,
    output logic [LW-1:0]              win_lvl,
    output logic                       any_enabled
);
    always_comb begin
        win_valid   = 1'b0;
        win_num     = '0;
        win_lvl     = '0;
        any_enabled = 1'b0;
        // scan downward so ties settle on the lowest number
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i] && lvl[i] != '0) begin
                any_enabled = 1'b1;
                if (lvl[i] >= win_lvl) begin
                    win_valid = 1'b1;
                    win_num   = VW'(i);
                    win_lvl   = lvl[i];
                end
            end
        end
    end
endmodule

// File: rtl/icu_vgen.sv
module icu_vgen #(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 21,
    localparam int VW = $clog2(NUM_SRC),
    localparam int LW = icu_pkg::LVL_W,
    localparam int NF = icu_pkg::NUM_FAST
) (
    input  logic                      win_valid,
    input  logic [VW-1:0]             win_num,
    input  logic [LW-1:0]             win_lvl,
    input  logic [ADDR_W-1:0]         base,
    input  logic [NF-1:0]             fen,
    input  logic [NF-1:0][VW-1:0]     fnum,
    input  logic [NF-1:0][ADDR_W-1:0] faddr,
    output logic [ADDR_W-1:0]         addr_o
);
    logic [NF-1:0] hit;
    logic [ADDR_W-1:0] table_addr;

    for (genvar p = 0; p < NF; p++) begin : g_hit
        assign hit[p] = fen[p] && (fnum[p] == win_num)
                        && (int'(win_lvl) == icu_pkg::FAST_LVL);
    end

    assign table_addr = base + (ADDR_W'(win_num) << 1);

    always_comb begin
        addr_o = table_addr;
        // highest index first so pair 0 is applied last and wins
        for (int p = NF - 1; p >= 0; p--)
            if (hit[p]) addr_o = faddr[p];
        if (!win_valid) addr_o = '0;
    end
endmodule

// File: rtl/icu_top.sv
module icu_top #(
    parameter int          NUM_SRC   = 8,
    parameter int          ADDR_W    = 21,
    parameter logic [20:0] RESET_VEC = 21'h1F0000,
    localparam int VW  = $clog2(NUM_SRC),
    localparam int RAW = $clog2(icu_pkg::PRIO_OFS + NUM_SRC),
    localparam int LW  = icu_pkg::LVL_W,
    localparam int NF  = icu_pkg::NUM_FAST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_n,
    input  logic               ack_valid_i,
    input  logic [VW-1:0]      ack_num_i,
    input  logic               wr_en_i,
    input  logic [RAW-1:0]     wr_addr_i,
    input  logic [ADDR_W-1:0]  wr_data_i,
    output logic               irq_valid_o,
    output logic [VW-1:0]      irq_num_o,
    output logic [ADDR_W-1:0]  vec_addr_o,
    output logic               wake_o,
    output logic               core_rst_req_o
);
    typedef struct packed {
        logic              valid;
        logic [VW-1:0]     num;
        logic [ADDR_W-1:0] addr;
        logic              wake;
    } out_t;

    out_t o_d, o_q;

    logic [NUM_SRC-1:0]         pend;
    logic [ADDR_W-1:0]          base;
    logic [NUM_SRC-1:0][LW-1:0] lvl;
    logic [NF-1:0]              fen;
    logic [NF-1:0][VW-1:0]      fnum;
    logic [NF-1:0][ADDR_W-1:0]  faddr;
    logic                       win_valid, any_en;
    logic [VW-1:0]              win_num;
    logic [LW-1:0]              win_lvl;
    logic [ADDR_W-1:0]          vaddr;

    icu_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n),
        .ack_valid(ack_valid_i), .ack_num(ack_num_i), .pend_o(pend)
    );

    icu_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
        .wr_data(wr_data_i), .base_o(base), .lvl_o(lvl), .fen_o(fen),
        .fnum_o(fnum), .faddr_o(faddr)
    );

    icu_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .pend(pend), .lvl(lvl), .win_valid(win_valid), .win_num(win_num),
        .win_lvl(win_lvl), .any_enabled(any_en)
    );

    icu_vgen #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_vgen (
        .win_valid(win_valid), .win_num(win_num), .win_lvl(win_lvl),
        .base(base), .fen(fen), .fnum(fnum), .faddr(faddr), .addr_o(vaddr)
    );

    always_comb begin
        o_d.valid = win_valid;
        o_d.num   = win_valid ? win_num : '0;
        o_d.addr  = vaddr;
        o_d.wake  = any_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign irq_valid_o    = o_q.valid;
    assign irq_num_o      = o_q.num;
    assign wake_o         = o_q.wake;
    assign vec_addr_o     = rst_n ? o_q.addr : ADDR_W'(RESET_VEC);
    assign core_rst_req_o = !rst_n;

    // R10
    valid_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> wake_o);
    // R11
    idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid_o |-> (vec_addr_o == '0 && irq_num_o == '0));
    // R11
    pend_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend == 1'b0) |=> !irq_valid_o);
endmodule

// File: tb/sim_icu_top.sv
module sim_icu_top;
    localparam int N = 8;
    logic clk = 0, rst_n = 0;
    logic [N-1:0] irq_n = '1;
    logic ack_valid = 0;
    logic [2:0] ack_num = '0;
    logic wr_en = 0;
    logic [3:0] wr_addr = '0;
    logic [20:0] wr_data = '0;
    logic irq_valid, wake, core_rst;
    logic [2:0] irq_num;
    logic [20:0] vec_addr;
    int n_chk = 0, n_fail = 0;
    logic [20:0] base = 21'h100;

    always #5 clk = ~clk;

    icu_top u0 (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .ack_valid_i(ack_valid),
        .ack_num_i(ack_num), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .irq_valid_o(irq_valid), .irq_num_o(irq_num),
        .vec_addr_o(vec_addr), .wake_o(wake), .core_rst_req_o(core_rst)
    );

    task automatic tick(input int k);
        repeat (k) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [20:0] d);
        wr_en = 1; wr_addr = 4'(a); wr_data = d;
        tick(1);
        wr_en = 0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        irq_n = irq_n & ~m;
        tick(1);
        irq_n = irq_n | m;
    endtask

    task automatic ack(input int v);
        ack_valid = 1; ack_num = 3'(v);
        tick(1);
        ack_valid = 0;
        tick(1);
    endtask

    task automatic expect_win(input string req, input int v, input logic [20:0] a);
        chk(req, {31'b0, irq_valid}, 1);
        chk(req, {29'b0, irq_num}, v);
        chk(req, {11'b0, vec_addr}, {11'b0, a});
        chk(req, {31'b0, wake}, 1);
    endtask

    task automatic expect_idle(input string req);
        chk(req, {31'b0, irq_valid}, 0);
        chk(req, {11'b0, vec_addr}, 0);
    endtask

    task automatic t_reset();
        tick(3);
        chk("R9", {31'b0, core_rst}, 1);
        chk("R9", {11'b0, vec_addr}, 32'h1F0000);
        chk("R9", {31'b0, irq_valid}, 0);
        rst_n = 1;
        tick(1);
        chk("R9", {31'b0, core_rst}, 0);
        expect_idle("R11");
        chk("R10", {31'b0, wake}, 0);
        // levels reset to zero: a pending source stays invisible
        pulse(8'h08);
        tick(1);
        expect_idle("R3");
        chk("R3", {31'b0, wake}, 0);
        ack(3);
    endtask

    task automatic t_edge();
        wr(0, base);
        wr(8 + 2, 21'd1);
        tick(2);
        expect_idle("R1");
        irq_n[2] = 0;
        tick(2);
        expect_win("R5", 2, base + 21'd4);
        ack(2);
        tick(1);
        expect_idle("R1");
        irq_n[2] = 1;
        tick(2);
        expect_idle("R1");
    endtask

    task automatic t_prio();
        wr(8 + 1, 21'd1); wr(8 + 5, 21'd3); wr(8 + 6, 21'd3); wr(8 + 4, 21'd2);
        pulse(8'h62);
        tick(1);
        expect_win("R4", 5, base + 21'd10);
        ack(5);
        expect_win("R4", 6, base + 21'd12);
        ack(6);
        expect_win("R4", 1, base + 21'd2);
        pulse(8'h10);
        tick(1);
        expect_win("R4", 4, base + 21'd8);
        ack(1);
        expect_win("R2", 4, base + 21'd8);
        ack(4);
        expect_idle("R2");
        chk("R10", {31'b0, wake}, 0);
    endtask

    task automatic t_fast();
        wr(1, 21'h100006);
        wr(2, 21'h1ABCDE);
        wr(8 + 6, 21'd2);
        pulse(8'h40);
        tick(1);
        expect_win("R6", 6, 21'h1ABCDE);
        wr(8 + 6, 21'd3);
        tick(1);
        expect_win("R7", 6, base + 21'd12);
        wr(8 + 6, 21'd2);
        wr(3, 21'h100006);
        wr(4, 21'h0F0F0F);
        tick(1);
        expect_win("R8", 6, 21'h1ABCDE);
        wr(1, 21'h000006);
        tick(1);
        expect_win("R6", 6, 21'h0F0F0F);
        ack(6);
        expect_idle("R6");
    endtask

    task automatic t_same_cycle();
        wr(8 + 3, 21'd1);
        pulse(8'h08);
        tick(1);
        expect_win("R2", 3, base + 21'd6);
        ack_valid = 1; ack_num = 3'd3; irq_n[3] = 0;
        tick(1);
        ack_valid = 0; irq_n[3] = 1;
        tick(1);
        expect_win("R2", 3, base + 21'd6);
        ack(3);
        expect_idle("R2");
        // level-0 source pending: no wake
        pulse(8'h80);
        tick(1);
        chk("R10", {31'b0, wake}, 0);
        expect_idle("R3");
        ack(7);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_edge();
        t_prio();
        t_fast();
        t_same_cycle();
        report();
    end

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule